// File: doc/BRIEF.md
# Serial Transmitter with Holding Stage

This block turns bytes written by a processor into an asynchronous serial bit stream on one output line. A single-entry holding stage sits in front of a frame shifter. The processor may therefore queue the next character while the current one is still going out. The shifter moves one bit per baud enable pulse. A frame is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. The character format comes from static configuration inputs, which are sampled when a character enters the shifter.

Two status outputs report progress, and they mean different things. `tx_ready` follows the holding stage: it says whether a write will be accepted. `tx_empty` signals underrun: it rises only once the last stop bit has been sent and nothing is waiting. An enable input gates the whole path. While the block is disabled, writes are refused and any character still in the holding stage is dropped.

Top module: `sertx_top`

## Requirements
- R1: After reset `txd` is 1, `tx_ready` is 0 and `tx_empty` is 1. The first clock edge that sees `tx_en` high makes `tx_ready` 1.
- R2: A write (`wr_stb` high while `tx_ready` is 1) fills the holding stage. From the next cycle `tx_ready` is 0.
- R3: A write made while `tx_ready` is 0 is ignored, and the character already held is the one sent.
- R4: While `tx_en` is 0, `tx_ready` is 0 and writes are refused. A held character is discarded one cycle after the disable takes effect. Neither is ever transmitted, including after the block is re-enabled.
- R5: When the shifter is idle and the holding stage is full, the character enters the shifter on the next `baud_tick`. `tx_ready` is 1 in the cycle after that tick.
- R6: `txd` changes only on clock edges where `baud_tick` is 1. A frame is start (0), then data LSB first, then parity if enabled, then stop bits (1). The line idles at 1.
- R7: The data length is 5 + `cfg_len` bits: `cfg_len` 0 gives 5 bits and 3 gives 8 bits. Bits of `wr_data` above that length are not sent.
- R8: With `cfg_par_en` = 1 a parity bit follows the data. With `cfg_par_odd` = 0 the count of ones in data plus parity is even; with `cfg_par_odd` = 1 it is odd.
- R9: `cfg_stop2` = 0 sends one stop bit and `cfg_stop2` = 1 sends two.
- R10: `tx_empty` is 0 while a frame is being shifted or a character is held. It becomes 1 in the cycle after the tick that ends the final stop bit, if the holding stage is empty.
- R11: A character held when a frame's last stop bit ends starts on that same tick. No idle bit period appears between the two frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter enable |
| wr_stb | input | 1 | Write strobe for the holding stage |
| wr_data | input | CHAR_MAX | Character to send |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| cfg_len | input | LEN_W | Data length select, bits = 5 + value |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Odd parity when 1, even when 0 |
| cfg_stop2 | input | 1 | Two stop bits when 1 |
| txd | output | 1 | Serial data line |
| tx_ready | output | 1 | Holding stage can accept a write |
| tx_empty | output | 1 | Nothing held and nothing being shifted |

## Verification
Two events can fall on the same edge: a frame's final stop bit ending, and a held character being loaded into the shifter. The bench provokes this by writing a second character as soon as `tx_ready` returns during the first frame. The scoreboard monitor then counts the idle bit periods it sees before the second start bit and expects none. A write that arrives while a character is already held is also issued one cycle after an accepted write. The bytes the monitor sees on the line then show whether the held character survived.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int unsigned CHAR_MAX_D = 8;
  localparam int unsigned CHAR_MIN_D = 5;
  localparam int unsigned LEN_W_D    = $clog2(CHAR_MAX_D - CHAR_MIN_D + 1);
  // start + data + parity + two stops
  localparam int unsigned FRAME_EXTRA = 4;
endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int unsigned CHAR_MAX = sertx_pkg::CHAR_MAX_D
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tx_en,
  input  logic                wr_stb,
  input  logic [CHAR_MAX-1:0] wr_data,
  input  logic                take,
  output logic                en_q,
  output logic                full,
  output logic [CHAR_MAX-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0;
      full <= 1'b0;
      data <= '0;
    end else begin
      en_q <= tx_en;
      if (!en_q) begin
        full <= 1'b0;                 // disabled: nothing is kept
      end else if (take) begin
        full <= 1'b0;
      end else if (wr_stb && !full) begin
        full <= 1'b1;
        data <= wr_data;
      end
    end
  end

  // R3: a write while already full leaves the held character untouched
  p_keep_held_r3: assert property (@(posedge clk) disable iff (rst)
    (full && wr_stb && !take) |=> (data == $past(data)));

  // R4: disabled state drains the holding stage
  p_drop_when_off_r4: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !full);
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift #(
  parameter int unsigned CHAR_MAX = sertx_pkg::CHAR_MAX_D,
  parameter int unsigned CHAR_MIN = sertx_pkg::CHAR_MIN_D,
  parameter int unsigned LEN_W    = sertx_pkg::LEN_W_D
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                load_ok,
  input  logic [CHAR_MAX-1:0] hold_data,
  input  logic [LEN_W-1:0]    fmt_len,
  input  logic                fmt_par,
  input  logic                fmt_odd,
  input  logic                fmt_stop2,
  output logic                take,
  output logic                busy,
  output logic                txd
);
  localparam int unsigned FRAME_W = CHAR_MAX + sertx_pkg::FRAME_EXTRA;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] frame;
  logic [FRAME_W-1:0] sh;
  logic [CNT_W-1:0]   flen;
  logic [CNT_W-1:0]   cnt;
  logic               par_bit;
  logic               more;
  int                 nchar;

  // assemble the whole frame from the held character and current format
  always_comb begin
    nchar = int'(CHAR_MIN) + int'(fmt_len);
    if (nchar > int'(CHAR_MAX)) nchar = int'(CHAR_MAX);
    frame    = '1;
    frame[0] = 1'b0;
    par_bit  = fmt_odd;
    for (int i = 0; i < int'(CHAR_MAX); i++) begin
      if (i < nchar) begin
        frame[i+1] = hold_data[i];
        par_bit    = par_bit ^ hold_data[i];
      end
    end
    if (fmt_par) frame[nchar+1] = par_bit;
    flen = CNT_W'(1 + nchar + (fmt_par ? 1 : 0) + (fmt_stop2 ? 2 : 1));
  end

  assign more = busy && (cnt > CNT_W'(1));
  assign take = tick && load_ok && !more;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      txd  <= 1'b1;
      sh   <= '1;
      cnt  <= '0;
    end else if (tick) begin
      if (more) begin
        txd <= sh[0];
        sh  <= {1'b1, sh[FRAME_W-1:1]};
        cnt <= cnt - CNT_W'(1);
      end else if (load_ok) begin
        txd  <= frame[0];
        sh   <= {1'b1, frame[FRAME_W-1:1]};
        cnt  <= flen;
        busy <= 1'b1;
      end else begin
        busy <= 1'b0;
        txd  <= 1'b1;
      end
    end
  end

  // R6: the line only moves on a baud enable
  p_step_on_tick_r6: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(txd));

  // R6: a load always begins with the low start bit
  p_start_low_r6: assert property (@(posedge clk) disable iff (rst)
    take |=> !txd);
endmodule

// File: rtl/sertx_top.sv
module sertx_top #(
  parameter int unsigned CHAR_MAX = sertx_pkg::CHAR_MAX_D,
  parameter int unsigned CHAR_MIN = sertx_pkg::CHAR_MIN_D,
  parameter int unsigned LEN_W    = sertx_pkg::LEN_W_D
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tx_en,
  input  logic                wr_stb,
  input  logic [CHAR_MAX-1:0] wr_data,
  input  logic                baud_tick,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic                cfg_par_en,
  input  logic                cfg_par_odd,
  input  logic                cfg_stop2,
  output logic                txd,
  output logic                tx_ready,
  output logic                tx_empty
);
  logic                en_q;
  logic                full;
  logic                take;
  logic                busy;
  logic [CHAR_MAX-1:0] hdata;

  sertx_hold #(.CHAR_MAX(CHAR_MAX)) u_hold (
    .clk(clk), .rst(rst), .tx_en(tx_en), .wr_stb(wr_stb), .wr_data(wr_data),
    .take(take), .en_q(en_q), .full(full), .data(hdata)
  );

  sertx_shift #(.CHAR_MAX(CHAR_MAX), .CHAR_MIN(CHAR_MIN), .LEN_W(LEN_W)) u_shift (
    .clk(clk), .rst(rst), .tick(baud_tick), .load_ok(en_q && full),
    .hold_data(hdata), .fmt_len(cfg_len), .fmt_par(cfg_par_en),
    .fmt_odd(cfg_par_odd), .fmt_stop2(cfg_stop2),
    .take(take), .busy(busy), .txd(txd)
  );

  assign tx_ready = en_q && !full;
  assign tx_empty = !busy && !full;

  // R4: a low enable blocks writes from the next cycle on
  p_ready_off_r4: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> !tx_ready);

  // R2: an accepted write occupies the holding stage
  p_write_fills_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && tx_ready) |=> !tx_ready);

  // R10: an empty transmitter leaves the line at idle level
  p_idle_high_r10: assert property (@(posedge clk) disable iff (rst)
    tx_empty |-> txd);

  // R10: underrun is only flagged after a high bit period ends
  p_empty_after_stop_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_empty) |-> $past(txd));
endmodule

// File: tb/tb_sertx_top.sv
`timescale 1ns/1ps
module tb_sertx_top;
  localparam int CW = 8;
  localparam int FW = CW + 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tx_en = 1'b0;
  logic          wr_stb = 1'b0;
  logic [CW-1:0] wr_data = '0;
  logic          baud_tick = 1'b0;
  logic [1:0]    cfg_len = 2'd3;
  logic          cfg_par_en = 1'b0;
  logic          cfg_par_odd = 1'b0;
  logic          cfg_stop2 = 1'b0;
  logic          txd, tx_ready, tx_empty;

  sertx_top dut (
    .clk(clk), .rst(rst), .tx_en(tx_en), .wr_stb(wr_stb), .wr_data(wr_data),
    .baud_tick(baud_tick), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_stop2(cfg_stop2),
    .txd(txd), .tx_ready(tx_ready), .tx_empty(tx_empty)
  );

  always #2.5 clk = ~clk;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  // scoreboard queues
  logic [FW-1:0] exp_q[$];
  int            len_q[$];
  string         tag_q[$];

  // monitor state
  int            tdiv = 0;
  bit            in_fr = 0;
  int            idx = 0;
  int            gap = 0;
  int            last_gap = -1;
  int            frames_seen = 0;
  bit            bad = 0;
  logic [FW-1:0] cur_exp, cur_got;
  int            cur_len = 0;
  string         cur_tag;

  task automatic check(input bit ok, input string tag, input int got, input int expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, expv);
    end
  endtask

  // baud generator and line monitor share one process to avoid races
  always @(negedge clk) begin
    bit tnext;
    tdiv  = (tdiv == 3) ? 0 : tdiv + 1;
    tnext = (tdiv == 3);
    if (!rst && tnext) begin
      if (!in_fr) begin
        if (txd == 1'b0) begin
          in_fr = 1; idx = 1; last_gap = gap; gap = 0; bad = 0;
          cur_got = '1; cur_got[0] = 1'b0;
          if (exp_q.size() == 0) begin
            cur_exp = '1; cur_len = 2; cur_tag = "R4"; bad = 1;
          end else begin
            cur_exp = exp_q.pop_front(); cur_len = len_q.pop_front();
            cur_tag = tag_q.pop_front();
          end
        end else begin
          gap++;
        end
      end else begin
        cur_got[idx] = txd;
        if (txd !== cur_exp[idx]) bad = 1;
        if (tx_empty) bad = 1;          // R10: empty must stay low mid-frame
        idx++;
        if (idx >= cur_len) begin
          in_fr = 0;
          frames_seen++;
          check(!bad, cur_tag, int'(cur_got), int'(cur_exp));
        end
      end
    end
    baud_tick <= tnext;
  end

  // expected frame straight from the requirements (R6..R9)
  task automatic build(input logic [CW-1:0] d, output logic [FW-1:0] f, output int n);
    int nb = 5 + int'(cfg_len);
    int ones = 0;
    f = '1; f[0] = 1'b0;
    for (int i = 0; i < nb; i++) begin
      f[i+1] = d[i];
      if (d[i]) ones++;
    end
    n = 1 + nb;
    if (cfg_par_en) begin
      f[n] = cfg_par_odd ? ((ones % 2) == 0) : ((ones % 2) == 1);
      n++;
    end
    n += cfg_stop2 ? 2 : 1;
  endtask

  task automatic wait_ready();
    int k = 0;
    @(negedge clk);
    while (!tx_ready && k < 500) begin @(negedge clk); k++; end
  endtask

  task automatic sync_tick();
    @(negedge clk);
    while (baud_tick !== 1'b1) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send(input logic [CW-1:0] d, input string tag);
    logic [FW-1:0] f;
    int n;
    wait_ready();
    build(d, f, n);
    exp_q.push_back(f); len_q.push_back(n); tag_q.push_back(tag);
    wr_data = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int k = 0;
    @(negedge clk);
    while ((exp_q.size() != 0 || in_fr || !tx_empty) && k < 2000) begin
      @(negedge clk); k++;
    end
    check(k < 2000, tag, k, 0);
    check(tx_empty === 1'b1, tag, int'(tx_empty), 1);   // R10
  endtask

  initial begin
    int fs;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(txd === 1'b1, "R1", int'(txd), 1);
    check(tx_ready === 1'b0, "R1", int'(tx_ready), 0);
    check(tx_empty === 1'b1, "R1", int'(tx_empty), 1);
    tx_en = 1'b1;
    @(negedge clk);
    check(tx_ready === 1'b1, "R1", int'(tx_ready), 1);

    // R2 / R5 / R6: single 8N1 character
    sync_tick();
    build(8'hA5, cur_exp, cur_len);
    exp_q.push_back(cur_exp); len_q.push_back(cur_len); tag_q.push_back("R6");
    wr_data = 8'hA5; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
    check(tx_ready === 1'b0, "R2", int'(tx_ready), 0);
    check(tx_empty === 1'b0, "R10", int'(tx_empty), 0);
    while (baud_tick !== 1'b1) @(negedge clk);
    check(tx_ready === 1'b1, "R5", int'(tx_ready), 1);
    wait_done("R10");

    // R3: second write while full must be dropped
    sync_tick();
    build(8'h3C, cur_exp, cur_len);
    exp_q.push_back(cur_exp); len_q.push_back(cur_len); tag_q.push_back("R3");
    wr_data = 8'h3C; wr_stb = 1'b1;
    @(negedge clk);
    wr_data = 8'hFF;
    @(negedge clk);
    wr_stb = 1'b0;
    wait_done("R3");

    // R7 / R8 / R9: formats
    cfg_len = 2'd0; cfg_par_en = 1'b1; cfg_par_odd = 1'b0; cfg_stop2 = 1'b0;
    send(8'hF6, "R7"); wait_done("R7");
    cfg_len = 2'd2; cfg_par_odd = 1'b1; cfg_stop2 = 1'b1;
    send(8'h5B, "R9"); wait_done("R9");
    cfg_len = 2'd1; cfg_par_en = 1'b0; cfg_stop2 = 1'b1;
    send(8'hED, "R7"); wait_done("R7");
    cfg_len = 2'd3; cfg_par_en = 1'b1; cfg_par_odd = 1'b0; cfg_stop2 = 1'b0;
    send(8'hFF, "R8"); wait_done("R8");
    cfg_par_odd = 1'b1;
    send(8'h00, "R8"); wait_done("R8");

    // R11: back-to-back, no gap
    cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
    send(8'h81, "R11");
    send(8'h7E, "R11");
    wait_done("R11");
    check(last_gap == 0, "R11", last_gap, 0);

    // R4: disabled writes are never sent
    fs = frames_seen;
    tx_en = 1'b0;
    repeat (2) @(negedge clk);
    check(tx_ready === 1'b0, "R4", int'(tx_ready), 0);
    wr_data = 8'h55; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
    repeat (40) @(negedge clk);
    check(txd === 1'b1, "R4", int'(txd), 1);
    tx_en = 1'b1;
    repeat (60) @(negedge clk);
    check(frames_seen == fs, "R4", frames_seen, fs);

    // R4: held character dropped on disable
    sync_tick();
    wr_data = 8'h99; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; tx_en = 1'b0;
    repeat (40) @(negedge clk);
    check(tx_empty === 1'b1, "R4", int'(tx_empty), 1);
    tx_en = 1'b1;
    repeat (60) @(negedge clk);
    check(frames_seen == fs && !in_fr, "R4", frames_seen, fs);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      check(1'b0, "watchdog", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule